// File: doc/BRIEF.md
# Card Clock Divider

This block derives the card-bus clock from the peripheral clock. It watches a 32-bit clock control word and a static pass-through strap input. A 4-bit code in bits 19:16 of the word picks a power-of-two divisor between /2 and /512. Bit 24 turns the card clock on or off. The block drives a 50%-duty divided clock and a one-cycle strobe in the peripheral clock domain. That strobe marks the first cycle of every high phase, so a command or data engine can step its shifters from it.

Code 15 is reserved. When the strap is 1, code 15 passes the peripheral clock straight through. When the strap is 0, code 15 falls back to the slowest rate. The block may be reprogrammed while it runs. A new code or enable state is adopted only at the end of a complete output period, when the output is already low, so no runt pulse or stretched pulse reaches the card. The timeout fields in bits 15:0 and every other unused bit of the word have no effect here.

The interface has no data stream: the control word, the strap and both outputs are plain level signals with no handshake.

Top module: `card_clk_div`

## Requirements
- R1: With bit 24 set and code n in bits 19:16 for n from 0 to 8, card_clk has a period of 2^(n+1) clock cycles. It is high for the first half of each period and low for the second half.
- R2: Codes 9 to 14 give the /512 rate: 256 cycles high, then 256 cycles low.
- R3: Code 15 with bypass_strap at 0 also gives the /512 rate.
- R4: Code 15 with bypass_strap at 1 makes card_clk follow clk, beginning with the clock cycle after the setting is adopted. rise_stb stays high in every cycle of this mode.
- R5: When bit 24 is cleared, card_clk is held low and rise_stb stays 0. This starts once the period in progress has finished.
- R6: Bits 31:25, 23:20 and 15:0 are ignored. Changing them while running does not disturb the phase or period of card_clk.
- R7: rise_stb is high for exactly one cycle, and that cycle is the first cycle of each high phase of the divided clock.
- R8: A change of code or enable while running takes effect only after the last (low) cycle of the current period. The next period starts high, at the new rate.
- R9: A synchronous active-high rst forces card_clk and rise_stb low and leaves the block disabled until the control word is adopted again.
- R10: When the block is disabled (including right after reset) and the word enables it, the first high phase starts at the first clock edge that sees the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 32 | Clock control word: enable in bit 24, divide code in bits 19:16 |
| bypass_strap | input | 1 | Static strap; 1 permits code 15 as undivided pass-through |
| card_clk | output | 1 | Card-bus clock |
| rise_stb | output | 1 | One-cycle strobe at the start of each card_clk high phase |

## Verification
The assertions assume two things about the inputs: rst is held for at least two edges, and bypass_strap is static while the block is out of reset. Under those conditions, the $past terms right after reset only see values that reset has cleared. The stimulus keeps to both rules. It changes the strap only while rst is asserted, and it changes the control word in the high phase of clk, well away from the sampling edge. Every legal and reserved code is swept with the strap both low and high. Run-time changes are applied at mid-period, in both the high and the low half, so the deferred adoption is exercised from both sides.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int CCD_SEL_W = 4;

  typedef struct packed {
    logic                 en;
    logic                 byp;
    logic [CCD_SEL_W-1:0] sel;
  } ccd_cfg_t;
endpackage

// File: rtl/ccd_decode.sv
module ccd_decode
  import ccd_pkg::*;
#(
  parameter int CTRL_W      = 32,
  parameter int CODE_LSB    = 16,
  parameter int CODE_W      = 4,
  parameter int EN_BIT      = 24,
  parameter int MAX_CODE    = 8,
  parameter int BYPASS_CODE = 15
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              bypass_strap,
  output ccd_cfg_t          want
);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] BYP_C = CODE_W'(BYPASS_CODE);

  logic [CODE_W-1:0] code;
  assign code = ctrl_word[CODE_LSB +: CODE_W];

  always_comb begin
    want = '0;
    if (ctrl_word[EN_BIT]) begin
      want.en = 1'b1;
      if (code == BYP_C && bypass_strap) begin
        want.byp = 1'b1;
      end else if (code <= MAX_C) begin
        want.sel = CCD_SEL_W'(code);
      end else begin
        want.sel = CCD_SEL_W'(MAX_CODE);
      end
    end
  end
endmodule

// File: rtl/ccd_counter.sv
module ccd_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cnt_next = clear ? '0 : cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_next;
  end
endmodule

// File: rtl/ccd_phase.sv
module ccd_phase
  import ccd_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  ccd_cfg_t         want,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             clear,
  output ccd_cfg_t         act,
  output logic             div_q,
  output logic             rise_stb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] low_mask(input logic [CCD_SEL_W-1:0] s);
    low_mask = (ONE << (s + 1'b1)) - ONE;
  endfunction

  ccd_cfg_t         act_n;
  logic             period_end;
  logic [CNT_W-1:0] cur_mask, nxt_mask, shifted;

  assign cur_mask   = low_mask(act.sel);
  assign period_end = act.byp | ~act.en | ((cnt & cur_mask) == cur_mask);
  assign clear      = (want != act) && period_end;
  assign act_n      = clear ? want : act;
  assign nxt_mask   = low_mask(act_n.sel);
  assign shifted    = cnt_next >> act_n.sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= '0;
      div_q    <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      act      <= act_n;
      div_q    <= act_n.en & ~act_n.byp & ~shifted[0];
      rise_stb <= act_n.en & (act_n.byp | ((cnt_next & nxt_mask) == '0));
    end
  end

  AST_ADOPT_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    ((act != $past(act)) && $past(act.en) && !$past(act.byp)) |-> !$past(div_q)); // R8
  AST_STB_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (rise_stb && !act.byp) |-> (div_q && !$past(div_q))); // R7
  AST_RISE_HAS_STB: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> rise_stb); // R7
  AST_BYPASS_STB: assert property (@(posedge clk) disable iff (rst)
    (act.en && act.byp) |-> rise_stb); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(act.en) |-> (!div_q && !rise_stb)); // R5
endmodule

// File: rtl/ccd_gate.sv
module ccd_gate (
  input  logic clk,
  input  logic rst,
  input  logic pass_on,
  input  logic div_q,
  output logic card_clk
);
  logic gate_q;

  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= pass_on;
  end

  assign card_clk = div_q | (clk & gate_q);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ccd_pkg::*;
#(
  parameter int CTRL_W      = 32,
  parameter int CODE_LSB    = 16,
  parameter int CODE_W      = 4,
  parameter int EN_BIT      = 24,
  parameter int MAX_CODE    = 8,
  parameter int BYPASS_CODE = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              bypass_strap,
  output logic              card_clk,
  output logic              rise_stb
);
  localparam int CNT_W = MAX_CODE + 1;

  ccd_cfg_t         want, act;
  logic             clear, div_q;
  logic [CNT_W-1:0] cnt, cnt_next;

  ccd_decode #(
    .CTRL_W(CTRL_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W),
    .EN_BIT(EN_BIT), .MAX_CODE(MAX_CODE), .BYPASS_CODE(BYPASS_CODE)
  ) u_decode (
    .ctrl_word(ctrl_word), .bypass_strap(bypass_strap), .want(want)
  );

  ccd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .clear(clear), .cnt(cnt), .cnt_next(cnt_next)
  );

  ccd_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .want(want), .cnt(cnt), .cnt_next(cnt_next),
    .clear(clear), .act(act), .div_q(div_q), .rise_stb(rise_stb)
  );

  ccd_gate u_gate (
    .clk(clk), .rst(rst), .pass_on(act.en & act.byp), .div_q(div_q),
    .card_clk(card_clk)
  );
endmodule

// File: tb/card_clk_div_tb_top.sv
`timescale 1ns/1ps
module card_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl = '0;
  logic        strap = 1'b0;
  wire         card_clk, rise_stb;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  card_clk_div dut_i (
    .clk(clk), .rst(rst), .ctrl_word(ctrl), .bypass_strap(strap),
    .card_clk(card_clk), .rise_stb(rise_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int period_of(input int code, input bit s);
    if (code == 15 && s) return 1;
    if (code <= 8) return 2 << code;
    return 512;
  endfunction

  // divided-mode expectation for sample index i of a period P
  task automatic chk_div(input int i, input int P, input string tag);
    chk(card_clk == ((i % P) < P / 2), {tag, " clk level"}, card_clk, (i % P) < P / 2);
    chk(rise_stb == ((i % P) == 0), {tag, " R7 strobe"}, rise_stb, (i % P) == 0);
  endtask

  // reset with a word already present; next step() is sample i=0 (R10)
  task automatic start(input logic [31:0] w, input bit s);
    step();
    rst = 1'b1; ctrl = w; strap = s;
    repeat (3) step();
    chk(card_clk == 1'b0 && rise_stb == 1'b0, "R9 reset quiet", {card_clk, rise_stb}, 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) step();
    chk(card_clk == 1'b0 && rise_stb == 1'b0, "R9 initial reset", {card_clk, rise_stb}, 0);

    // Sweep every code with the strap low and high: R1 R2 R3 R4 R7 R10
    for (int s = 0; s < 2; s++) begin
      for (int code = 0; code < 16; code++) begin
        int    P;
        string tag;
        P = period_of(code, s[0]);
        if (code <= 8) tag = "R1";
        else if (code < 15) tag = "R2";
        else if (s == 0) tag = "R3";
        else tag = "R4";
        start(32'h0100_2FFF | (code << 16), s[0]);
        if (P == 1) begin
          for (int i = 0; i < 16; i++) begin
            step();
            if (i > 0) chk(card_clk == 1'b1, "R4 high with clk", card_clk, 1);
            chk(rise_stb == 1'b1, "R4 strobe every cycle", rise_stb, 1);
            #2.5;
            if (i > 0) chk(card_clk == 1'b0, "R4 low with clk", card_clk, 0);
            #(-0.0);
          end
        end else begin
          for (int i = 0; i < 2 * P; i++) begin
            step();
            chk_div(i, P, tag);
          end
        end
      end
    end

    // R6: ignored bits changed mid-period on /4
    start(32'h0101_2FFF, 1'b0);
    for (int i = 0; i < 16; i++) begin
      step();
      chk_div(i, 4, "R6");
      if (i == 5) ctrl = 32'hFF21_A5A5;
    end

    // R8: /8 -> /2 requested in the high half
    start(32'h0102_2FFF, 1'b0);
    for (int i = 0; i < 16; i++) begin
      step();
      if (i < 8) chk_div(i, 8, "R8 old rate");
      else chk_div(i - 8, 2, "R8 new rate");
      if (i == 3) ctrl = 32'h0100_2FFF;
    end

    // R8: /2 -> /8 requested in the low half
    start(32'h0100_2FFF, 1'b0);
    for (int i = 0; i < 20; i++) begin
      step();
      if (i < 2) chk_div(i, 2, "R8 old rate");
      else chk_div(i - 2, 8, "R8 new rate");
      if (i == 1) ctrl = 32'h0102_2FFF;
    end

    // R5: disable mid-period on /4, period completes then stays low
    start(32'h0101_2FFF, 1'b0);
    for (int i = 0; i < 12; i++) begin
      step();
      if (i < 4) chk_div(i, 4, "R5 finish");
      else chk(card_clk == 1'b0 && rise_stb == 1'b0, "R5 held low", {card_clk, rise_stb}, 0);
      if (i == 1) ctrl = 32'h0001_2FFF;
    end

    // R5/R10: start disabled, code changes ignored, then enable at once
    start(32'h0003_2FFF, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(card_clk == 1'b0 && rise_stb == 1'b0, "R5 disabled quiet", {card_clk, rise_stb}, 0);
      if (i == 2) ctrl = 32'h0005_0000;
    end
    ctrl = 32'h0100_2FFF;
    for (int i = 0; i < 6; i++) begin
      step();
      chk_div(i, 2, "R10 enable");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule